// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block watches a master clock and the left/right frame clock of an audio sample stream. It measures how many master clock cycles pass in each frame and works out which supported master-clock-to-sample-rate ratio is in use. No pin or register selects the ratio. The supported ratios are 128, 192, 256, 384, 512 and 768 times the sample rate. The two smallest ratios put the converter into high-rate operation.

The detector reports a ratio code, a high-rate flag and the oversampling factor the modulator must use: 128 in normal operation and 64 in high-rate operation. It also reports a lock indication and a mute request for the downstream interpolation and modulator logic. The outputs only qualify that logic and do not drive it. Any sample rate from a few kHz up to the top rate is handled, as long as the cycle count per frame matches a supported ratio.

Top module: `mclk_ratio_detect`

## Requirements
- R1: During and right after reset, ratioCode is 7, locked is 0, muteReq is 1, highRate is 0 and osrFactor is 128.
- R2: One frame length is the number of master clock cycles from one LRCLK rising edge to the next. LRCLK passes through two synchroniser flops first. The first rising edge after reset, or after an R9 timeout, only starts a measurement and is not classified.
- R3: A frame length within ±2 cycles of a nominal ratio is classified as that ratio, coded 0=128, 1=192, 2=256, 3=384, 4=512, 5=768.
- R4: A frame length outside every tolerance window is an unsupported frame (code 7). It clears locked and restarts the agreement count.
- R5: locked rises after the third consecutive classified frame with the same code. At that point ratioCode takes that code.
- R6: A classified frame whose code differs from the previous one clears locked. While locked is 0, ratioCode, highRate and osrFactor keep their last values.
- R7: highRate is 1 and osrFactor is 64 when ratioCode is 0 or 1. Otherwise highRate is 0 and osrFactor is 128.
- R8: muteReq is always the inverse of locked.
- R9: If 1023 cycles pass after a measured rising edge with no further rising edge, the frame counts as unsupported and locked clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| lrclk | input | 1 | Left/right frame clock, asynchronous to mclk in phase |
| ratioCode | output | 3 | Detected ratio code, 7 when none |
| highRate | output | 1 | High-rate operation selected |
| osrFactor | output | 8 | Modulator oversampling factor (64 or 128) |
| locked | output | 1 | Ratio agreed over enough consecutive frames |
| muteReq | output | 1 | Downstream mute request |

## Verification
Two things can happen on the same frame edge: one frame ends the agreement run of the old ratio and also starts a new run, or a mismatch unlocks the detector while the held ratio outputs must not move. This is provoked by switching the LRCLK period directly from one ratio to another, both while locked and one frame before lock. It is also provoked by placing boundary lengths (nominal ±2 and ±3) right after locked runs. A frame-by-frame reference model in the bench predicts lock, code and the derived outputs after every rising edge, and the outputs are compared a few cycles into each frame.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  localparam int NUM_RATIOS = 6;
  localparam logic [2:0] CODE_NONE = 3'd7;

  // nominal cycles per frame for code idx: 128,192,256,384,512,768
  function automatic int nominalOf(input int idx);
    int base;
    base = 128 << (idx / 2);
    return (idx % 2 == 1) ? base + base / 2 : base;
  endfunction

  typedef struct packed {
    logic       done;   // one frame measurement finished this cycle
    logic [2:0] code;   // classification of that frame
  } frameStrobe_t;
endpackage

// File: rtl/mrd_datapath.sv
module mrd_datapath
  import mrd_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOL   = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         lrclk,
  output frameStrobe_t frm
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic syncA, syncB, syncPrev;
  logic rise;
  logic havePrev;
  logic [CNT_W-1:0] cnt;
  logic [NUM_RATIOS-1:0] hit;
  logic [2:0] measCode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= lrclk;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign rise = syncB & ~syncPrev;

  // tolerance windows, one comparator pair per ratio
  for (genvar g = 0; g < NUM_RATIOS; g++) begin : gWin
    localparam logic [CNT_W-1:0] LO = CNT_W'(nominalOf(g) - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(nominalOf(g) + TOL);
    assign hit[g] = (cnt >= LO) && (cnt <= HI);
  end

  always_comb begin
    measCode = CODE_NONE;
    for (int i = NUM_RATIOS - 1; i >= 0; i--)
      if (hit[i]) measCode = 3'(i);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= CNT_MAX;
      havePrev <= 1'b0;
      frm      <= '{done: 1'b0, code: CODE_NONE};
    end else begin
      frm.done <= 1'b0;
      if (rise) begin
        cnt      <= CNT_W'(1);
        havePrev <= 1'b1;
        if (havePrev) begin
          frm.done <= 1'b1;
          frm.code <= measCode;
        end
      end else begin
        if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
        if (havePrev && cnt == CNT_MAX) begin
          frm.done <= 1'b1;
          frm.code <= CODE_NONE;
          havePrev <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mrd_control.sv
module mrd_control
  import mrd_pkg::*;
#(
  parameter int LOCK_FRAMES = 3,
  parameter int OSR_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  frameStrobe_t     frm,
  output logic [2:0]       ratioCode,
  output logic             highRate,
  output logic [OSR_W-1:0] osrFactor,
  output logic             locked,
  output logic             muteReq
);
  localparam int AG_W = $clog2(LOCK_FRAMES + 1);
  localparam logic [AG_W-1:0] AG_FULL = AG_W'(LOCK_FRAMES);
  localparam logic [OSR_W-1:0] OSR_NORMAL = OSR_W'(128);
  localparam logic [OSR_W-1:0] OSR_HIGH   = OSR_W'(64);

  logic [AG_W-1:0] agree, agreeNext;
  logic [2:0] lastCode;
  logic lockNext;

  always_comb begin
    agreeNext = agree;
    lockNext  = locked;
    if (frm.code == CODE_NONE) begin
      agreeNext = '0;
      lockNext  = 1'b0;
    end else if (agree != '0 && frm.code == lastCode) begin
      if (agree != AG_FULL) agreeNext = agree + AG_W'(1);
    end else begin
      agreeNext = AG_W'(1);
      lockNext  = 1'b0;
    end
    if (agreeNext == AG_FULL) lockNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      agree     <= '0;
      lastCode  <= CODE_NONE;
      locked    <= 1'b0;
      muteReq   <= 1'b1;
      ratioCode <= CODE_NONE;
      highRate  <= 1'b0;
      osrFactor <= OSR_NORMAL;
    end else if (frm.done) begin
      agree    <= agreeNext;
      lastCode <= frm.code;
      locked   <= lockNext;
      muteReq  <= ~lockNext;
      if (lockNext) begin
        ratioCode <= frm.code;
        highRate  <= (frm.code < 3'd2);
        osrFactor <= (frm.code < 3'd2) ? OSR_HIGH : OSR_NORMAL;
      end
    end
  end
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mrd_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int TOL         = 2,
  parameter int LOCK_FRAMES = 3,
  parameter int OSR_W       = 8
) (
  input  logic             mclk,
  input  logic             rstN,
  input  logic             lrclk,
  output logic [2:0]       ratioCode,
  output logic             highRate,
  output logic [OSR_W-1:0] osrFactor,
  output logic             locked,
  output logic             muteReq
);
  frameStrobe_t frm;

  mrd_datapath #(.CNT_W(CNT_W), .TOL(TOL)) uData (
    .clk(mclk), .rstN(rstN), .lrclk(lrclk), .frm(frm)
  );

  mrd_control #(.LOCK_FRAMES(LOCK_FRAMES), .OSR_W(OSR_W)) uCtrl (
    .clk(mclk), .rstN(rstN), .frm(frm),
    .ratioCode(ratioCode), .highRate(highRate), .osrFactor(osrFactor),
    .locked(locked), .muteReq(muteReq)
  );
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker #(
  parameter int OSR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             frmDone,
  input logic [2:0]       ratioCode,
  input logic             highRate,
  input logic [OSR_W-1:0] osrFactor,
  input logic             locked,
  input logic             muteReq
);
  a_r8_mute_inverse: assert property (@(posedge clk) disable iff (!rstN)
    muteReq != locked);

  a_r5_locked_has_code: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> ratioCode != 3'd7);

  a_r5_lock_on_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(frmDone));

  a_r6_hold_code: assert property (@(posedge clk) disable iff (!rstN)
    !locked |=> (locked || $stable(ratioCode)));

  a_r7_rate_flag: assert property (@(posedge clk) disable iff (!rstN)
    highRate == (ratioCode < 3'd2));

  a_r7_osr_value: assert property (@(posedge clk) disable iff (!rstN)
    osrFactor == (highRate ? OSR_W'(64) : OSR_W'(128)));
endmodule

bind mclk_ratio_detect mrd_checker #(.OSR_W(OSR_W)) uChk (
  .clk(mclk), .rstN(rstN), .frmDone(frm.done), .ratioCode(ratioCode),
  .highRate(highRate), .osrFactor(osrFactor), .locked(locked), .muteReq(muteReq)
);

// File: tb/tb_mclk_ratio_detect.sv
`timescale 1ns/1ps
module tb_mclk_ratio_detect;
  logic mclk = 0, rstN = 0, lrclk = 0;
  logic [2:0] ratioCode;
  logic highRate, locked, muteReq;
  logic [7:0] osrFactor;

  mclk_ratio_detect dut (.mclk(mclk), .rstN(rstN), .lrclk(lrclk),
    .ratioCode(ratioCode), .highRate(highRate), .osrFactor(osrFactor),
    .locked(locked), .muteReq(muteReq));

  always #2.5 mclk = ~mclk;

  int nChecks = 0, nFail = 0;
  // reference model state
  int mAgree = 0, mLast = 7, mCode = 7, mPrevLen = 0;
  bit mLocked = 0, mHavePrev = 0;

  function automatic int nominal(int idx);
    int b = 128 << (idx / 2);
    return (idx % 2) ? b + b / 2 : b;
  endfunction

  function automatic int classify(int len);
    for (int i = 0; i < 6; i++)
      if (len >= nominal(i) - 2 && len <= nominal(i) + 2) return i;
    return 7;
  endfunction

  task automatic modelFrame(int code);
    if (code == 7) begin mAgree = 0; mLocked = 0; end
    else if (mAgree != 0 && code == mLast) begin if (mAgree < 3) mAgree++; end
    else begin mAgree = 1; mLocked = 0; end
    mLast = code;
    if (mAgree >= 3) begin mLocked = 1; mCode = code; end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    int expHigh = (mCode < 2) ? 1 : 0;
    chk(tag, "locked", locked, mLocked);
    chk("R8", "muteReq", muteReq, !mLocked);
    chk(tag, "ratioCode", ratioCode, mCode);
    chk("R7", "highRate", highRate, expHigh);
    chk("R7", "osrFactor", osrFactor, expHigh ? 64 : 128);
  endtask

  task automatic frame(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge mclk); #1;
      lrclk = (i < n / 2);
      if (i == 0) begin
        if (mHavePrev) modelFrame(classify(mPrevLen));
        mHavePrev = 1; mPrevLen = n;
      end
      if (i == 9) checkAll(tag);
    end
  endtask

  task automatic frames(int n, int k, string tag);
    for (int j = 0; j < k; j++) frame(n, tag);
  endtask

  task automatic doReset();
    @(posedge mclk); #1; rstN = 0; lrclk = 0;
    repeat (3) @(posedge mclk);
    #1;
    mAgree = 0; mLast = 7; mCode = 7; mLocked = 0; mHavePrev = 0;
    checkAll("R1");
    rstN = 1;
    @(posedge mclk); #1;
    checkAll("R1");
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0726);
    doReset();
    // R2: first edge only starts; two frames not enough for lock
    frames(256, 3, "R2");
    chk("R2", "locked after 2 measured", locked, 0);
    frame(256, "R5");
    chk("R5", "locked after 3 measured", locked, 1);
    chk("R5", "code 256", ratioCode, 2);
    // every nominal ratio
    for (int r = 0; r < 6; r++) frames(nominal(r), 5, "R3");
    // R6: direct switch while locked
    frames(512, 5, "R6");
    frames(384, 2, "R6");
    chk("R6", "held code after mismatch", ratioCode, 4);
    chk("R6", "unlocked after mismatch", locked, 0);
    frames(384, 3, "R6");
    // switch one frame before lock
    frames(192, 3, "R6");
    frames(768, 4, "R6");
    // boundaries
    frames(128 + 2, 4, "R3");
    frames(768 - 2, 4, "R3");
    frames(256 + 3, 3, "R4");
    chk("R4", "unlock on +3", locked, 0);
    frames(256 - 2, 4, "R3");
    frames(384 - 3, 2, "R4");
    frames(192, 4, "R3");
    // R9: stuck LRCLK
    for (int i = 0; i < 1100; i++) begin @(posedge mclk); #1; lrclk = 0; end
    if (mHavePrev) modelFrame(7);
    mHavePrev = 0;
    checkAll("R9");
    chk("R9", "unlocked on timeout", locked, 0);
    chk("R9", "held code on timeout", ratioCode, 1);
    frames(512, 4, "R9");
    // reset mid-run
    doReset();
    frames(768, 4, "R5");
    // random segments
    for (int s = 0; s < 30; s++) begin
      int idx = $urandom_range(5, 0);
      int off = $urandom_range(8, 0) - 4;
      int k = $urandom_range(5, 1);
      frames(nominal(idx) + off, k, (off > 2 || off < -2) ? "R4" : "R3");
    end
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge mclk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule